// File: doc/BRIEF.md
# Bus Address and Chip-Select Decoder

This block sits between a 16-bit processor bus, where the low address bits and the data share the same wires, and the memory and peripheral chips behind it. While the address-latch strobe is high, it captures the full address together with the memory/IO strobe and the active-low high-byte enable. Once the strobe falls, it holds those values and drives them to the chips as a demultiplexed address. From the held values it derives active-low selects for three pairs of byte-lane chips: two read-only banks, two RAM banks and two 8-bit peripherals. It also passes a two-bit register select to the peripherals.

Decoding is linear. One address bit enables the read-only banks and another enables the RAM banks. The memory/IO strobe alone separates memory cycles from port cycles. RAM and peripheral selects are qualified per byte lane, so that a byte access reaches only the chip on the matching half of the data bus. A word access at an even address reaches both chips of the pair. The read-only pair always shares one select, because reading the unused lane does no harm.

Top module: `busdec_top`

## Requirements
- R1: While `rst_n` is low, all six chip selects are high (inactive). After reset and before the first address-latch strobe, they also stay high.
- R2: While `ale` is high, all six chip selects are high, whatever is on the bus.
- R3: In a memory cycle (`mio`=1) with latched address bit 13 equal to 1, `rom_even_cs_n` and `rom_odd_cs_n` are both low, whatever the values of `bhe_n` and address bit 0. The two read-only selects are always equal.
- R4: In a memory cycle with latched address bits 13 and 14 both 0, `ram_even_cs_n` is low exactly when address bit 0 is 0, and `ram_odd_cs_n` is low exactly when `bhe_n` is 0.
- R5: When address bits 13=1 and 14=0 in a memory cycle, only the read-only selects go low. The read-only decode takes priority, so at most one memory type is ever selected.
- R6: In a memory cycle with address bit 13=0 and bit 14=1, no select goes low. An address in the reset-vector region (0xFFFF0) selects only the read-only pair.
- R7: In a port cycle (`mio`=0), `io_even_cs_n` is low exactly when address bit 0 is 0, and `io_odd_cs_n` is low exactly when `bhe_n` is 0. No address bit other than bit 0 takes part in this decode.
- R8: A port cycle never lowers a memory select, and a memory cycle never lowers a peripheral select.
- R9: `reg_sel` equals latched address bits 2 down to 1, and `addr_lat` equals the full latched address.
- R10: After `ale` falls, changes on `bus_ad`, `bus_ahi`, `mio` and `bhe_n` change none of the outputs until `ale` rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ale | input | 1 | Address-latch strobe; the address is captured while it is high |
| bus_ad | input | 16 | Multiplexed low address and data |
| bus_ahi | input | 4 | Upper address bits 19..16 |
| mio | input | 1 | 1 for a memory cycle, 0 for a port cycle |
| bhe_n | input | 1 | Active-low high-byte enable |
| rom_even_cs_n | output | 1 | Even read-only bank select, active low |
| rom_odd_cs_n | output | 1 | Odd read-only bank select, active low |
| ram_even_cs_n | output | 1 | Even RAM bank select, active low |
| ram_odd_cs_n | output | 1 | Odd RAM bank select, active low |
| io_even_cs_n | output | 1 | Low-lane peripheral select, active low |
| io_odd_cs_n | output | 1 | High-lane peripheral select, active low |
| reg_sel | output | 2 | Peripheral register select from address bits 2..1 |
| addr_lat | output | 20 | Held demultiplexed address |

## Verification
The bench builds the block with its default parameters. These give a 20-bit address, with the read-only decode on bit 13, the RAM decode on bit 14 and the register select on bits 2..1. Both decode bits are reachable through the low bus word, so every combination of them can be driven in turn. The upper address nibble reaches the reset-vector region at 0xFFFF0. The byte-lane cases (even byte, odd byte, word) are each run against RAM, read-only memory and peripheral cycles.

// File: rtl/busdec_pkg.sv
// Package busdec_pkg
// Shared lane indices and the internal select bundle of the bus decoder.
// Assumes two byte lanes: lane 0 carries the low data byte and lane 1 the high byte.
package busdec_pkg;

    localparam int LANE_CNT  = 2;
    localparam int LANE_LOW  = 0;
    localparam int LANE_HIGH = 1;

    // Active-high select requests before gating and inversion.
    typedef struct packed {
        logic                rom;
        logic [LANE_CNT-1:0] ram;
        logic [LANE_CNT-1:0] io;
    } sel_req_t;

    localparam sel_req_t SEL_NONE = '{rom: 1'b0, ram: '0, io: '0};

endpackage

// File: rtl/busdec_latch.sv
// Module busdec_latch
// Captures the address and the cycle qualifiers while the latch strobe is high,
// and holds them once it falls. The valid flag marks that at least one address
// has been captured since reset.
// Assumes a strobe that stays high for at least one clock edge per bus cycle.
module busdec_latch #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              mio_in,
    input  logic              bhe_n_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic              mio_q,
    output logic              bhe_n_q,
    output logic              valid_q
);

    // Capture the address and qualifiers on every edge that sees the strobe high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            mio_q   <= 1'b0;
            bhe_n_q <= 1'b1;
            valid_q <= 1'b0;
        end else if (ale) begin
            addr_q  <= addr_in;
            mio_q   <= mio_in;
            bhe_n_q <= bhe_n_in;
            valid_q <= 1'b1;
        end
    end

endmodule

// File: rtl/busdec_lane.sv
// Module busdec_lane
// Derives the per-lane enables from address bit 0 and the high-byte enable.
// The low lane is enabled when bit 0 is 0. The high lane is enabled when
// bhe_n is 0. A word access at an even address enables both lanes.
module busdec_lane
    import busdec_pkg::*;
(
    input  logic                a0,
    input  logic                bhe_n,
    output logic [LANE_CNT-1:0] lane_en
);

    for (genvar g = 0; g < LANE_CNT; g++) begin : g_lane
        if (g == LANE_LOW) begin : g_low
            // Low lane follows address bit 0.
            always_comb lane_en[g] = ~a0;
        end else begin : g_high
            // High lane follows the high-byte enable.
            always_comb lane_en[g] = ~bhe_n;
        end
    end

endmodule

// File: rtl/busdec_mem.sv
// Module busdec_mem
// Linear memory decode. The read-only pair is selected by a set ROM bit and
// ignores the lanes. The RAM pair is selected by a clear RAM bit, and each RAM
// bank is qualified by its lane. The read-only decode wins when both apply.
// Assumes the caller gates the result with the memory-cycle flag.
module busdec_mem
    import busdec_pkg::*;
(
    input  logic                mem_cycle,
    input  logic                rom_bit,
    input  logic                ram_bit,
    input  logic [LANE_CNT-1:0] lane_en,
    output logic                rom_hit,
    output logic [LANE_CNT-1:0] ram_hit
);

    logic ram_region;

    // Read-only region: bit set during a memory cycle, lanes ignored.
    always_comb rom_hit = mem_cycle & rom_bit;

    // RAM region: bit clear, and the read-only region is not hit (priority).
    always_comb ram_region = mem_cycle & ~ram_bit & ~rom_hit;

    for (genvar g = 0; g < LANE_CNT; g++) begin : g_ram
        // Qualify each RAM bank with its byte lane.
        always_comb ram_hit[g] = ram_region & lane_en[g];
    end

endmodule

// File: rtl/busdec_io.sv
// Module busdec_io
// Port-space decode. No address line is spent on it: a port cycle selects
// each peripheral whose byte lane is enabled.
// Assumes one 8-bit peripheral on each lane.
module busdec_io
    import busdec_pkg::*;
(
    input  logic                io_cycle,
    input  logic [LANE_CNT-1:0] lane_en,
    output logic [LANE_CNT-1:0] io_hit
);

    for (genvar g = 0; g < LANE_CNT; g++) begin : g_io
        // Select the peripheral on this lane during a port cycle.
        always_comb io_hit[g] = io_cycle & lane_en[g];
    end

endmodule

// File: rtl/busdec_top.sv
// Module busdec_top
// Address latch and chip-select decoder for a multiplexed 16-bit bus.
// The address is held from the last strobe, and the active-low selects are
// decoded from the held value. All selects stay inactive during reset, while
// the strobe is high, and until the first address has been captured.
// Assumes ROM_BIT, RAM_BIT and the register-select field lie inside the address.
module busdec_top #(
    parameter int AD_W     = 16,
    parameter int AHI_W    = 4,
    parameter int ROM_BIT  = 13,
    parameter int RAM_BIT  = 14,
    parameter int RSEL_LSB = 1,
    parameter int RSEL_W   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ale,
    input  logic [AD_W-1:0]          bus_ad,
    input  logic [AHI_W-1:0]         bus_ahi,
    input  logic                     mio,
    input  logic                     bhe_n,
    output logic                     rom_even_cs_n,
    output logic                     rom_odd_cs_n,
    output logic                     ram_even_cs_n,
    output logic                     ram_odd_cs_n,
    output logic                     io_even_cs_n,
    output logic                     io_odd_cs_n,
    output logic [RSEL_W-1:0]        reg_sel,
    output logic [AD_W+AHI_W-1:0]    addr_lat
);
    import busdec_pkg::*;

    localparam int ADDR_W = AD_W + AHI_W;

    logic [ADDR_W-1:0]   addr_q;
    logic                mio_q;
    logic                bhe_n_q;
    logic                valid_q;
    logic [LANE_CNT-1:0] lane_en;
    logic                rom_hit;
    logic [LANE_CNT-1:0] ram_hit;
    logic [LANE_CNT-1:0] io_hit;
    logic                drive_ok;
    sel_req_t            req;
    sel_req_t            req_gated;

    busdec_latch #(.ADDR_W(ADDR_W)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .ale      (ale),
        .addr_in  ({bus_ahi, bus_ad}),
        .mio_in   (mio),
        .bhe_n_in (bhe_n),
        .addr_q   (addr_q),
        .mio_q    (mio_q),
        .bhe_n_q  (bhe_n_q),
        .valid_q  (valid_q)
    );

    busdec_lane u_lane (
        .a0      (addr_q[0]),
        .bhe_n   (bhe_n_q),
        .lane_en (lane_en)
    );

    busdec_mem u_mem (
        .mem_cycle (mio_q),
        .rom_bit   (addr_q[ROM_BIT]),
        .ram_bit   (addr_q[RAM_BIT]),
        .lane_en   (lane_en),
        .rom_hit   (rom_hit),
        .ram_hit   (ram_hit)
    );

    busdec_io u_io (
        .io_cycle (~mio_q),
        .lane_en  (lane_en),
        .io_hit   (io_hit)
    );

    // Collect the raw select requests into one bundle.
    always_comb req = '{rom: rom_hit, ram: ram_hit, io: io_hit};

    // Selects may drive only out of reset, with a held address, and strobe low.
    always_comb drive_ok = rst_n & valid_q & ~ale;

    // Force every request off when driving is not allowed.
    always_comb req_gated = drive_ok ? req : SEL_NONE;

    // Invert to active-low pins; the read-only pair shares one select.
    always_comb begin
        rom_even_cs_n = ~req_gated.rom;
        rom_odd_cs_n  = ~req_gated.rom;
        ram_even_cs_n = ~req_gated.ram[LANE_LOW];
        ram_odd_cs_n  = ~req_gated.ram[LANE_HIGH];
        io_even_cs_n  = ~req_gated.io[LANE_LOW];
        io_odd_cs_n   = ~req_gated.io[LANE_HIGH];
    end

    // Held address and the peripheral register select taken from it.
    always_comb begin
        addr_lat = addr_q;
        reg_sel  = addr_q[RSEL_LSB +: RSEL_W];
    end

endmodule

// File: rtl/busdec_checker.sv
// Module busdec_checker
// Temporal checks on the decoder ports, attached to every busdec_top by bind.
module busdec_checker #(
    parameter int RSEL_W = 2,
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ale,
    input logic              rom_even_cs_n,
    input logic              rom_odd_cs_n,
    input logic              ram_even_cs_n,
    input logic              ram_odd_cs_n,
    input logic              io_even_cs_n,
    input logic              io_odd_cs_n,
    input logic [RSEL_W-1:0] reg_sel,
    input logic [ADDR_W-1:0] addr_lat
);

    logic [5:0] cs_n;
    logic       mem_any;
    logic       io_any;
    logic       rom_any;
    logic       ram_any;

    always_comb begin
        cs_n    = {rom_even_cs_n, rom_odd_cs_n, ram_even_cs_n, ram_odd_cs_n,
                   io_even_cs_n, io_odd_cs_n};
        rom_any = ~rom_even_cs_n | ~rom_odd_cs_n;
        ram_any = ~ram_even_cs_n | ~ram_odd_cs_n;
        mem_any = rom_any | ram_any;
        io_any  = ~io_even_cs_n | ~io_odd_cs_n;
    end

    // R1: reset keeps every select inactive.
    a_r1_reset_idle: assert property (@(posedge clk) !rst_n |-> cs_n == 6'h3F);

    // R2: an active strobe keeps every select inactive.
    a_r2_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> cs_n == 6'h3F);

    // R3: the two read-only selects move together.
    a_r3_rom_pair: assert property (@(posedge clk) disable iff (!rst_n)
        rom_even_cs_n == rom_odd_cs_n);

    // R5: never both memory types at once.
    a_r5_one_mem_type: assert property (@(posedge clk) disable iff (!rst_n)
        !(rom_any && ram_any));

    // R8: memory and port selects are never active together.
    a_r8_space_split: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_any && io_any));

    // R10: with the strobe low across two edges, the outputs hold.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ale && $past(!ale) && $past(rst_n)) |->
        ($stable(cs_n) && $stable(reg_sel) && $stable(addr_lat)));

endmodule

bind busdec_top busdec_checker #(
    .RSEL_W (RSEL_W),
    .ADDR_W (AD_W + AHI_W)
) u_busdec_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .ale           (ale),
    .rom_even_cs_n (rom_even_cs_n),
    .rom_odd_cs_n  (rom_odd_cs_n),
    .ram_even_cs_n (ram_even_cs_n),
    .ram_odd_cs_n  (ram_odd_cs_n),
    .io_even_cs_n  (io_even_cs_n),
    .io_odd_cs_n   (io_odd_cs_n),
    .reg_sel       (reg_sel),
    .addr_lat      (addr_lat)
);

// File: tb/busdec_top_test.sv
module busdec_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ale = 1'b0;
    logic [15:0] bus_ad = '0;
    logic [3:0]  bus_ahi = '0;
    logic        mio = 1'b0;
    logic        bhe_n = 1'b1;
    logic        rom_even_cs_n, rom_odd_cs_n, ram_even_cs_n, ram_odd_cs_n;
    logic        io_even_cs_n, io_odd_cs_n;
    logic [1:0]  reg_sel;
    logic [19:0] addr_lat;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    busdec_top uut (
        .clk(clk), .rst_n(rst_n), .ale(ale), .bus_ad(bus_ad), .bus_ahi(bus_ahi),
        .mio(mio), .bhe_n(bhe_n),
        .rom_even_cs_n(rom_even_cs_n), .rom_odd_cs_n(rom_odd_cs_n),
        .ram_even_cs_n(ram_even_cs_n), .ram_odd_cs_n(ram_odd_cs_n),
        .io_even_cs_n(io_even_cs_n), .io_odd_cs_n(io_odd_cs_n),
        .reg_sel(reg_sel), .addr_lat(addr_lat)
    );

    function automatic logic [5:0] cs_now();
        return {rom_even_cs_n, rom_odd_cs_n, ram_even_cs_n, ram_odd_cs_n,
                io_even_cs_n, io_odd_cs_n};
    endfunction

    // Expected selects from the requirements (R3..R8), active low.
    function automatic logic [5:0] expect_cs(input logic [19:0] a, input logic m,
                                             input logic bh);
        logic rom, ram, lo, hi;
        rom = m && a[13];
        ram = m && !a[13] && !a[14];
        lo  = !a[0];
        hi  = !bh;
        return ~{rom, rom, ram && lo, ram && hi, !m && lo, !m && hi};
    endfunction

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One bus cycle: strobe the address, drop the strobe, scramble the bus, check.
    task automatic bus_cycle(input string req, input logic [19:0] a,
                             input logic m, input logic bh);
        @(negedge clk);
        ale = 1'b1; bus_ad = a[15:0]; bus_ahi = a[19:16]; mio = m; bhe_n = bh;
        @(negedge clk);
        check("R2", {26'd0, cs_now()}, 32'h3F);
        ale = 1'b0;
        bus_ad = ~a[15:0]; bus_ahi = ~a[19:16]; mio = ~m; bhe_n = ~bh;
        @(negedge clk);
        check(req, {26'd0, cs_now()}, {26'd0, expect_cs(a, m, bh)});
        check("R9", {10'd0, addr_lat, reg_sel}, {10'd0, a, a[2:1]});
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1", {26'd0, cs_now()}, 32'h3F);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {26'd0, cs_now()}, 32'h3F);
    endtask

    task automatic t_rom();
        bus_cycle("R3", 20'h02000, 1'b1, 1'b1);
        bus_cycle("R3", 20'h02001, 1'b1, 1'b0);
        bus_cycle("R3", 20'h06000, 1'b1, 1'b0);
        bus_cycle("R6", 20'hFFFF0, 1'b1, 1'b0);
    endtask

    task automatic t_ram();
        bus_cycle("R4", 20'h00100, 1'b1, 1'b1);
        bus_cycle("R4", 20'h00101, 1'b1, 1'b0);
        bus_cycle("R4", 20'h00102, 1'b1, 1'b0);
        bus_cycle("R4", 20'h00103, 1'b1, 1'b1);
    endtask

    task automatic t_priority();
        bus_cycle("R5", 20'h02100, 1'b1, 1'b0);
        bus_cycle("R6", 20'h04100, 1'b1, 1'b0);
    endtask

    task automatic t_io();
        bus_cycle("R7", 20'h00040, 1'b0, 1'b1);
        bus_cycle("R7", 20'h00043, 1'b0, 1'b0);
        bus_cycle("R7", 20'h06006, 1'b0, 1'b0);
        bus_cycle("R8", 20'h02000, 1'b0, 1'b1);
        bus_cycle("R8", 20'h00000, 1'b1, 1'b0);
    endtask

    task automatic t_regsel();
        for (int i = 0; i < 4; i++)
            bus_cycle("R9", 20'h00080 | (i << 1), 1'b0, 1'b1);
    endtask

    task automatic t_hold();
        logic [5:0] held;
        bus_cycle("R10", 20'h00204, 1'b1, 1'b0);
        held = cs_now();
        repeat (5) begin
            @(negedge clk);
            bus_ad = bus_ad + 16'h2345; bus_ahi = bus_ahi + 4'd3;
            mio = ~mio; bhe_n = ~bhe_n;
        end
        @(negedge clk);
        check("R10", {26'd0, cs_now()}, {26'd0, held});
        check("R10", {12'd0, addr_lat}, 32'h00204);
    endtask

    initial begin
        t_reset();
        t_rom();
        t_ram();
        t_priority();
        t_io();
        t_regsel();
        t_hold();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule